// File: doc/BRIEF.md
# Pausible Local Clock Controller with Per-Requester Arbitration

This block generates a local clock for a consumer domain. Any number of external producers can halt that clock safely so that each can load the consumer's input register while the clock stands still. It is written in synchronous form. A fast sampling clock drives a divider, and the divider produces the local clock level and a one-cycle enable at each rising edge. The length of each half-period is a parameter counted in sampling cycles.

Every producer owns a request/acknowledge pair. The block gives each pair its own arbiter. That arbiter weighs the producer's request against the clock's own wish to take its next rising edge. An acknowledge is granted only while the local clock is low, and the clock stays low for as long as any acknowledge is held. The arbiters' "clock may run" outputs are ANDed ahead of the divider, which plays the part of the oscillation loop. While the clock is held, the divider keeps its count, so the low phase is stretched and never cut short.

A mode input selects what happens when the last producer lets go:
- **Pausible mode:** the clock resumes free-running.
- **Stoppable mode:** the clock delivers exactly one full cycle and then parks low until the next release.

Top module: `pclk_ctrl`

## Requirements
- R1: While reset is asserted and in the first sample after it, the local clock is low, the enable is low and every acknowledge is low.
- R2: In pausible mode with no request, the local clock has a period of exactly 2*HALF_CYC sampling cycles, high and low for HALF_CYC each.
- R3: A request that is sampled high while the clock is low, and is not in conflict with a rising edge, raises its acknowledge one sampling cycle later. While any acknowledge is high, the clock stays low.
- R4: An acknowledge is never high while the local clock is high. A request raised during a high phase is acknowledged one sampling cycle after the falling edge.
- R5: If a request is first sampled in the same sampling cycle in which the clock takes its rising edge, the clock wins. That high phase runs in full, and the request is acknowledged one sampling cycle after the following falling edge. A request sampled one cycle earlier wins, and it holds the clock low.
- R6: Each acknowledge falls one sampling cycle after its own request is sampled low. The clock stays held until every acknowledge is low (AND of all arbiters).
- R7: No high phase is longer or shorter than HALF_CYC sampling cycles. No low phase is shorter than HALF_CYC.
- R8: In pausible mode the divider keeps its count while held. A low phase therefore lasts HALF_CYC plus the number of sampling cycles in which some acknowledge was high during it.
- R9: In stoppable mode (stop_mode = 1), the clock takes no rising edge after reset until a release. Each release, meaning the sampling cycle in which the last high acknowledge falls, yields exactly one rising edge, after which the clock parks low.
- R10: lclk_en is high for exactly the first sampling cycle of each high phase and low otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stop_mode | input | 1 | 0: resume free-running after release; 1: one cycle per release |
| req | input | NREQ | One pause request per producer |
| ack | output | NREQ | Acknowledge per producer; high only while the clock is held low |
| lclk | output | 1 | Local clock level |
| lclk_en | output | 1 | One-sampling-cycle pulse at the start of each high phase |

## Verification
Two events can fall on the same sampling cycle: a producer's request becoming pending and the divider's own rising edge at the end of a low phase. The bench provokes the clash by timing a request so that it is sampled exactly at the cycle of the rising edge. It expects the clock to win, to run a full high phase with the acknowledge low, and to grant the acknowledge one cycle after the next fall. It then shifts the same request one cycle earlier and expects the opposite outcome. Random request traffic in both modes keeps producing such collisions, and a cycle monitor judges every phase length, every acknowledge against the clock level, and every rise of the enable.

// File: rtl/pclk_pkg.sv
package pclk_pkg;

   typedef enum logic {
      MODE_PAUSIBLE  = 1'b0,
      MODE_STOPPABLE = 1'b1
   } pclk_mode_e;

   function automatic int cnt_width(input int half_cyc);
      return (half_cyc > 1) ? $clog2(half_cyc) : 1;
   endfunction

endpackage

// File: rtl/pclk_div.sv
module pclk_div #(
   parameter int HALF_CYC = 4,
   parameter int CNT_W    = pclk_pkg::cnt_width(HALF_CYC)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic lclk,
   output logic adv,
   output logic lclk_en
);

   logic at_end;
   logic lclk_q;
   logic en_q;

   if (HALF_CYC < 1) begin : g_bad_half
      $error("pclk_div: HALF_CYC must be at least 1");
   end

   generate
      if (HALF_CYC == 1) begin : g_toggle
         assign at_end = 1'b1;
      end else begin : g_count
         logic [CNT_W-1:0] cnt_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (run) begin
               if (at_end) cnt_q <= '0;
               else        cnt_q <= cnt_q + 1'b1;
            end
         end
         assign at_end = (cnt_q == CNT_W'(HALF_CYC - 1));
      end
   endgenerate

   assign adv = run && at_end;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lclk_q <= 1'b0;
         en_q   <= 1'b0;
      end else begin
         lclk_q <= lclk_q ^ adv;
         en_q   <= adv && !lclk_q;
      end
   end

   assign lclk    = lclk_q;
   assign lclk_en = en_q;

   // R10: the enable pulse lasts exactly one sampling cycle
   assert_en_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
      lclk_en |=> !lclk_en);

endmodule

// File: rtl/pclk_arb.sv
module pclk_arb (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   input  logic lclk,
   input  logic adv,
   output logic grant
);

   logic grant_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         grant_q <= 1'b0;
      end else if (grant_q) begin
         grant_q <= req;
      end else begin
         grant_q <= req && !lclk && !adv;
      end
   end

   assign grant = grant_q;

   assert_ack_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !req |=> !grant);

   assert_clock_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!grant && adv && !lclk) |=> !grant);

   assert_no_ack_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
      lclk |-> !grant);

endmodule

// File: rtl/pclk_rel.sv
module pclk_rel (
   input  logic clk,
   input  logic rst_n,
   input  logic any_grant,
   input  logic fall,
   output logic armed
);

   logic any_q;
   logic armed_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         any_q   <= 1'b0;
         armed_q <= 1'b0;
      end else begin
         any_q <= any_grant;
         if (any_q && !any_grant) armed_q <= 1'b1;
         else if (fall)           armed_q <= 1'b0;
      end
   end

   assign armed = armed_q;

endmodule

// File: rtl/pclk_ctrl.sv
module pclk_ctrl #(
   parameter int NREQ     = 3,
   parameter int HALF_CYC = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            stop_mode,
   input  logic [NREQ-1:0] req,
   output logic [NREQ-1:0] ack,
   output logic            lclk,
   output logic            lclk_en
);
   import pclk_pkg::*;

   localparam int CNT_W = cnt_width(HALF_CYC);
   localparam int LEN_W = CNT_W + 1;

   if (NREQ < 1) begin : g_bad_nreq
      $error("pclk_ctrl: NREQ must be at least 1");
   end

   pclk_mode_e      mode;
   logic [NREQ-1:0] grant;
   logic [NREQ-1:0] free_vec;
   logic            clock_free;
   logic            any_grant;
   logic            armed;
   logic            run;
   logic            adv;
   logic            lclk_i;

   assign mode = pclk_mode_e'(stop_mode);

   generate
      for (genvar i = 0; i < NREQ; i++) begin : g_arb
         pclk_arb u_arb (
            .clk   (clk),
            .rst_n (rst_n),
            .req   (req[i]),
            .lclk  (lclk_i),
            .adv   (adv),
            .grant (grant[i])
         );
         assign free_vec[i] = !grant[i];
      end
   endgenerate

   assign clock_free = &free_vec;
   assign any_grant  = !clock_free;

   pclk_rel u_rel (
      .clk       (clk),
      .rst_n     (rst_n),
      .any_grant (any_grant),
      .fall      (adv && lclk_i),
      .armed     (armed)
   );

   assign run = clock_free && (lclk_i || (mode == MODE_PAUSIBLE) || armed);

   pclk_div #(
      .HALF_CYC (HALF_CYC),
      .CNT_W    (CNT_W)
   ) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run),
      .lclk    (lclk_i),
      .adv     (adv),
      .lclk_en (lclk_en)
   );

   assign lclk = lclk_i;
   assign ack  = grant;

   // observer for the high-phase length
   logic [LEN_W-1:0] hi_len_q;
   always_ff @(posedge clk) begin
      if (!rst_n)      hi_len_q <= '0;
      else if (lclk_i) hi_len_q <= hi_len_q + 1'b1;
      else             hi_len_q <= '0;
   end

   assert_hi_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(lclk_i) |-> (hi_len_q == LEN_W'(HALF_CYC)));

   assert_hold_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ((|ack) && !lclk_i) |=> !lclk_i);

   assert_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !((|ack) && lclk_i));

   assert_single_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_mode && $fell(lclk_i)) |=> (!lclk_i || !stop_mode));

endmodule

// File: tb/pclk_ctrl_test.sv
module pclk_ctrl_test;

   localparam int CLK_PERIOD = 10;
   localparam int NREQ       = 3;
   localparam int HALF       = 4;

   logic            clk = 1'b0;
   logic            rst_n;
   logic            stop_mode;
   logic [NREQ-1:0] req;
   logic [NREQ-1:0] ack;
   logic            lclk;
   logic            lclk_en;

   int vectors = 0;
   int fails   = 0;
   bit done    = 0;

   pclk_ctrl #(.NREQ(NREQ), .HALF_CYC(HALF)) uut (
      .clk(clk), .rst_n(rst_n), .stop_mode(stop_mode),
      .req(req), .ack(ack), .lclk(lclk), .lclk_en(lclk_en)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input bit ok, input string rq, input int act, input int exp);
      vectors++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d at %0t", rq, act, exp, $time);
      end
   endtask

   function automatic int exp_low_len(input int holds);
      return HALF + holds;
   endfunction

   // step to a quarter period after the next rising sampling edge
   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #(CLK_PERIOD/4);
   endtask

   task automatic wait_fall();
      @(negedge lclk);
      #(CLK_PERIOD/4);
   endtask

   task automatic wait_rise();
      @(posedge lclk);
      #(CLK_PERIOD/4);
   endtask

   // ---------------- cycle monitor ----------------
   logic            p_lclk;
   logic [NREQ-1:0] p_ack, p_req;
   int hi_len, lo_len, lo_hold, rise_cnt;
   bit lo_valid;

   always @(negedge clk) begin
      if (!rst_n) begin
         p_lclk <= 1'b0; p_ack <= '0; p_req <= '0;
         hi_len = 0; lo_len = 0; lo_hold = 0; lo_valid = 0;
      end else begin
         chk(!(lclk && (|ack)), "R4 ack with clock high", int'(ack), 0);
         for (int i = 0; i < NREQ; i++)
            if (ack[i] && !p_ack[i])
               chk(p_req[i] && !p_lclk, "R3 ack rise without low-phase request",
                   int'(p_req[i]), 1);
         if (lclk && !p_lclk) begin
            rise_cnt++;
            chk(lclk_en == 1'b1, "R10 enable at rise", int'(lclk_en), 1);
            if (lo_valid) begin
               chk(lo_len >= HALF, "R7 low phase length", lo_len, HALF);
               if (!stop_mode)
                  chk(lo_len == exp_low_len(lo_hold), "R8 low phase stretch",
                      lo_len, exp_low_len(lo_hold));
            end
            hi_len = 1;
         end else begin
            chk(lclk_en == 1'b0, "R10 enable outside rise", int'(lclk_en), 0);
            if (lclk) hi_len++;
         end
         if (!lclk && p_lclk) begin
            chk(hi_len == HALF, "R7 high phase length", hi_len, HALF);
            lo_valid = 1;
            lo_len = 0; lo_hold = 0;
         end
         if (!lclk) begin
            lo_len++;
            if (|ack) lo_hold++;
         end
         p_lclk <= lclk; p_ack <= ack; p_req <= req;
      end
   end

   // ---------------- watchdog ----------------
   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   task automatic do_reset(input logic mode);
      rst_n = 1'b0; req = '0; stop_mode = mode;
      step(3);
      chk(lclk == 1'b0 && lclk_en == 1'b0 && ack == '0, "R1 reset state",
          int'({lclk, lclk_en, ack}), 0);
      rst_n = 1'b1;
      step(1);
      chk(lclk == 1'b0 && lclk_en == 1'b0 && ack == '0, "R1 after reset",
          int'({lclk, lclk_en, ack}), 0);
   endtask

   task automatic rand_traffic(input int cycles);
      for (int c = 0; c < cycles; c++) begin
         for (int i = 0; i < NREQ; i++) begin
            if (!req[i]) begin
               if (($urandom % 16) == 0) req[i] = 1'b1;
            end else if (($urandom % 6) == 0) begin
               req[i] = 1'b0;
            end
         end
         step(1);
      end
      req = '0;
      step(4 * HALF);
   endtask

   initial begin
      int unsigned seed;
      int k, r0, hold, t0;
      seed = $urandom(32'd2024);
      rst_n = 1'b0; req = '0; stop_mode = 1'b0;

      // ---- pausible mode ----
      do_reset(1'b0);

      // R2: free-running period
      wait_fall();
      t0 = 0;
      wait_fall();
      t0 = 1;
      k = 0;
      while (lclk == 1'b0) begin step(1); k++; end
      chk(k == HALF, "R2 low half-period", k, HALF);
      k = 0;
      while (lclk == 1'b1) begin step(1); k++; end
      chk(k == HALF && t0 == 1, "R2 high half-period", k, HALF);

      // R3 / R6: single request, hold, release
      wait_fall();
      req[0] = 1'b1;
      step(1);
      chk(ack[0] == 1'b1, "R3 ack one cycle after request", int'(ack[0]), 1);
      for (int j = 0; j < 6; j++) begin
         step(1);
         chk(lclk == 1'b0, "R3 clock held low", int'(lclk), 0);
      end
      req[0] = 1'b0;
      step(1);
      chk(ack[0] == 1'b0, "R6 ack drops after request", int'(ack[0]), 0);

      // R4: request during high phase
      wait_rise();
      req[1] = 1'b1;
      for (int j = 1; j <= HALF; j++) begin
         step(1);
         chk(ack[1] == 1'b0, "R4 no ack before fall", int'(ack[1]), 0);
      end
      chk(lclk == 1'b0, "R4 clock fell", int'(lclk), 0);
      step(1);
      chk(ack[1] == 1'b1, "R4 ack one cycle after fall", int'(ack[1]), 1);
      req[1] = 1'b0;
      step(2);

      // R5: conflict with the rising edge
      wait_fall();
      step(HALF - 1);
      req[2] = 1'b1;
      step(1);
      chk(lclk == 1'b1 && ack[2] == 1'b0, "R5 clock wins the tie",
          int'({lclk, ack[2]}), 2);
      step(HALF);
      chk(lclk == 1'b0 && ack[2] == 1'b0, "R5 no ack at fall",
          int'({lclk, ack[2]}), 0);
      step(1);
      chk(ack[2] == 1'b1, "R5 ack after following fall", int'(ack[2]), 1);
      req[2] = 1'b0;
      step(2);

      // R5: one cycle earlier the request wins
      wait_fall();
      step(HALF - 2);
      req[2] = 1'b1;
      step(1);
      chk(ack[2] == 1'b1, "R5 early request granted", int'(ack[2]), 1);
      step(1);
      chk(lclk == 1'b0, "R5 early request holds clock", int'(lclk), 0);
      req[2] = 1'b0;
      step(2);

      // R6: two producers, AND of releases
      wait_fall();
      req[0] = 1'b1; req[1] = 1'b1;
      step(2);
      chk(ack[1:0] == 2'b11, "R6 both acks", int'(ack[1:0]), 3);
      req[0] = 1'b0;
      step(1);
      chk(ack[1:0] == 2'b10, "R6 independent ack drop", int'(ack[1:0]), 2);
      step(3);
      chk(lclk == 1'b0, "R6 clock held by remaining ack", int'(lclk), 0);
      req[1] = 1'b0;
      step(1);
      chk(ack == '0, "R6 all acks low", int'(ack), 0);
      k = 0;
      while (lclk == 1'b0 && k < 2 * HALF) begin step(1); k++; end
      chk(lclk == 1'b1, "R6 clock resumes", int'(lclk), 1);

      // R8: low phase stretched by exactly the hold count
      wait_fall();
      k = 0;
      while (lclk == 1'b0 && k < 4 * HALF) begin
         step(1); k++;
         if (k == 1) req[0] = 1'b1;
         if (k == 6) req[0] = 1'b0;
      end
      chk(k == exp_low_len(5), "R8 divider holds its count", k, exp_low_len(5));

      rand_traffic(3000);

      // ---- stoppable mode ----
      do_reset(1'b1);
      r0 = rise_cnt;
      step(6 * HALF);
      chk(rise_cnt == r0 && lclk == 1'b0, "R9 parked after reset", rise_cnt - r0, 0);

      for (int round = 0; round < 6; round++) begin
         int idx;
         idx  = $urandom % NREQ;
         hold = 1 + ($urandom % 5);
         req[idx] = 1'b1;
         if (round == 5) req[(idx + 1) % NREQ] = 1'b1;
         step(2);
         chk(ack[idx] == 1'b1, "R9 ack while parked", int'(ack[idx]), 1);
         step(hold);
         req[idx] = 1'b0;
         if (round == 5) begin
            step(3);
            chk(lclk == 1'b0, "R6 held by second producer", int'(lclk), 0);
            req = '0;
         end
         r0 = rise_cnt;
         step(4 * HALF + 6);
         chk(rise_cnt - r0 == 1, "R9 one rise per release", rise_cnt - r0, 1);
         chk(lclk == 1'b0, "R9 parked low after cycle", int'(lclk), 0);
      end

      rand_traffic(2000);

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule